// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous SRAM with 18-bit words, organised as two 9-bit lanes. Each lane is one data byte plus its parity bit. Every input except the output enable and the burst-order select is captured on the rising clock edge. These inputs are the address, the three chip selects, the two start strobes, burst advance, the write controls and the write data. Read data then passes through an output register, so the memory has a registered-in, registered-out pipeline. Data in and data out share one bidirectional bus.

An access starts with one of two strobes, a host strobe or a controller strobe. Either strobe loads the address and samples the chip selects. After that, each cycle with burst advance low steps a 2-bit counter over the low two address bits. The step follows either an interleaved (XOR) order or a linear (wrapping add) order, chosen by the burst-order select. Each cycle after the start is a read or a write, depending on the write controls sampled in that cycle. A write whose address is read on the next command returns the new data. A deselecting start stops the chip from driving the bus from the cycle after next.

Top module: `sync_burst_sram`

## Requirements
- R1: A start (either strobe) selects the chip only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. A start with any of them inactive gives no read data and no array writes until the next selecting start, whatever burst-advance and write inputs follow.
- R2: The host strobe `stb_host_n` is honoured only while `sel_a_n`=0. With `sel_a_n`=1 it is ignored, and a burst already in progress continues as if no strobe had been given.
- R3: A read command captured on edge k drives the word on `dq` from just after edge k+1, provided `out_en_n` is low. Each further read command in a burst yields its word one cycle after the previous one.
- R4: The word address is {start address upper bits, low2}. In interleaved order (`seq_linear`=0), low2 = start_low2 XOR count. In linear order (`seq_linear`=1), low2 = (start_low2 + count) mod 4. The count is reset to 0 by a start, rises by 1 (wrapping at 4) on each edge with `burst_adv_n`=0, and holds when `burst_adv_n`=1.
- R5: With `wr_byte_n`=0, `wr_lo_n`=0 writes lane `dq[8:0]` (data bits 7:0, parity bit 8) and `wr_hi_n`=0 writes lane `dq[17:9]` (data bits 16:9, parity bit 17). With `wr_byte_n`=1 both lane enables have no effect.
- R6: `wr_all_n`=0 writes all 18 bits, whatever `wr_byte_n`, `wr_lo_n` and `wr_hi_n` are.
- R7: A start taken through the host strobe is always a read. Write controls sampled on that edge are ignored. A write to the same address may follow on the next edge with `burst_adv_n`=1.
- R8: A read of an address on the command right after a write to it returns the newly written word, merged per lane with the old contents.
- R9: `out_en_n`=1 puts `dq` in high impedance immediately, without waiting for a clock edge.
- R10: After reset `dq` is high impedance. A deselecting start on edge k leaves `dq` high impedance from just after edge k+1.
- R11: After a write command on edge k, the block does not drive `dq` in the cycle after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state (not the array) |
| addr | input | AW | Word address, loaded on a start |
| sel_a_n | input | 1 | Active-low chip select; also gates the host strobe |
| sel_b_n | input | 1 | Active-low chip select |
| sel_c | input | 1 | Active-high chip select |
| stb_host_n | input | 1 | Active-low host start strobe (read start only) |
| stb_ctl_n | input | 1 | Active-low controller start strobe |
| burst_adv_n | input | 1 | Active-low burst advance |
| wr_all_n | input | 1 | Active-low write of both lanes |
| wr_byte_n | input | 1 | Active-low qualifier for the lane enables |
| wr_lo_n | input | 1 | Active-low lower-lane write enable |
| wr_hi_n | input | 1 | Active-low upper-lane write enable |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| dq | inout | 2*LANE | Shared data bus |

## Verification
The bench aims at the burst walk with a start address in the middle of a group of four. In interleaved order a wrong sequencer would show the linear order, or the reverse. At a hold cycle it would step the count instead of repeating the word. It writes single lanes, and lane enables with the qualifier inactive, where a wrong decode corrupts the other lane or writes when it should not. It also tries a write on a host-strobe start, which a faulty design would commit. It reads right after a write, which would give stale data if the write and the following read were not ordered. It gives a host strobe with its gating select high in mid-burst, which a faulty design would take as a restart at a new address. Finally it checks bus release after deselects, writes and an output-enable drop, where a design that got this wrong would keep driving the shared bus.

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram #(
  parameter int AW   = 6,
  parameter int LANE = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          sel_a_n,
  input  logic          sel_b_n,
  input  logic          sel_c,
  input  logic          stb_host_n,
  input  logic          stb_ctl_n,
  input  logic          burst_adv_n,
  input  logic          wr_all_n,
  input  logic          wr_byte_n,
  input  logic          wr_lo_n,
  input  logic          wr_hi_n,
  input  logic          out_en_n,
  input  logic          seq_linear,
  inout  wire [2*LANE-1:0] dq
);
  localparam int DW    = 2 * LANE;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          act_q, rd_q, wr_q, drv_q;
  logic [AW-1:0] base_q, a_q;
  logic [1:0]    cnt_q, wbe_q;
  logic [DW-1:0] wd_q, dout_q;

  wire host_go = !stb_host_n && !sel_a_n;
  wire start   = host_go || !stb_ctl_n;
  wire sel     = !sel_a_n && !sel_b_n && sel_c;
  wire w_lo    = !wr_all_n || (!wr_byte_n && !wr_lo_n);
  wire w_hi    = !wr_all_n || (!wr_byte_n && !wr_hi_n);

  wire          act_d  = start ? sel : act_q;
  wire [AW-1:0] base_d = start ? addr : base_q;
  wire [1:0]    cnt_d  = start ? 2'd0 : (burst_adv_n ? cnt_q : cnt_q + 2'd1);
  wire [1:0]    low_d  = seq_linear ? base_d[1:0] + cnt_d : base_d[1:0] ^ cnt_d;
  wire          wr_d   = act_d && !host_go && (w_lo || w_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= 2'd0;
      a_q    <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      a_q    <= {base_d[AW-1:2], low_d};
      rd_q   <= act_d && !wr_d;
      wr_q   <= wr_d;
      drv_q  <= rd_q;
    end
  end

  always_ff @(posedge clk) begin
    wd_q   <= dq;
    wbe_q  <= {w_hi, w_lo};
    dout_q <= mem[a_q];
    if (wr_q && wbe_q[0]) mem[a_q][LANE-1:0]  <= wd_q[LANE-1:0];
    if (wr_q && wbe_q[1]) mem[a_q][DW-1:LANE] <= wd_q[DW-1:LANE];
  end

  assign dq = (!out_en_n && drv_q) ? dout_q : {DW{1'bz}};

  AST_WRITE_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n) wr_q |=> !drv_q) else $error("write followed by drive"); // R11
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (start && !sel) |=> (!rd_q && !wr_q)) else $error("deselected access active"); // R10
  AST_HOST_START_READS: assert property (@(posedge clk) disable iff (!rst_n) host_go |=> !wr_q) else $error("host start wrote"); // R7
  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!start && burst_adv_n) |=> (cnt_q == $past(cnt_q))) else $error("burst count moved"); // R4
endmodule

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/1ps
module test_sync_burst_sram;
  localparam int AW = 6;
  localparam int DW = 18;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] a;
  logic sa_n, sb_n, sc, hs_n, cs_n, adv_n, gw_n, bw_n, lo_n, hi_n, oe_n, lin;
  logic oe_req;
  logic [DW-1:0] wd, tb_d;
  logic tb_en = 1'b0;
  wire  [DW-1:0] dq;

  assign dq = tb_en ? tb_d : {DW{1'bz}};
  always #2 clk = ~clk;

  sync_burst_sram #(.AW(AW), .LANE(9)) i_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(a), .sel_a_n(sa_n), .sel_b_n(sb_n), .sel_c(sc),
    .stb_host_n(hs_n), .stb_ctl_n(cs_n), .burst_adv_n(adv_n), .wr_all_n(gw_n),
    .wr_byte_n(bw_n), .wr_lo_n(lo_n), .wr_hi_n(hi_n), .out_en_n(oe_n),
    .seq_linear(lin), .dq(dq)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R10";
  logic [DW-1:0] ref_mem [DEPTH];
  logic m_act = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0] m_cnt = 0;
  logic pend_v = 0;
  logic [DW-1:0] pend_d = '0;

  function automatic logic [AW-1:0] baddr(logic [AW-1:0] b, logic [1:0] c, logic l);
    logic [1:0] lw = l ? b[1:0] + c : b[1:0] ^ c;
    return {b[AW-1:2], lw};
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] o, logic [DW-1:0] d, logic l, logic h);
    return {h ? d[17:9] : o[17:9], l ? d[8:0] : o[8:0]};
  endfunction

  function automatic logic [DW-1:0] pat(int i);
    return 18'(i * 32'h2B7 + 32'h1151);
  endfunction

  task automatic idle();
    hs_n = 1; cs_n = 1; adv_n = 1; sa_n = 0; sb_n = 0; sc = 1;
    gw_n = 1; bw_n = 1; lo_n = 1; hi_n = 1; oe_req = 0;
  endtask

  task automatic tick();
    logic hg, st, sl, wl, wh, wr, rd;
    logic [AW-1:0] ea;
    logic [DW-1:0] exp_v;
    hg = !hs_n && !sa_n;
    st = hg || !cs_n;
    sl = !sa_n && !sb_n && sc;
    if (st) begin m_act = sl; m_base = a; m_cnt = 0; end
    else if (!adv_n) m_cnt = m_cnt + 2'd1;
    ea = baddr(m_base, m_cnt, lin);
    wl = !gw_n || (!bw_n && !lo_n);
    wh = !gw_n || (!bw_n && !hi_n);
    wr = m_act && !hg && (wl || wh);
    rd = m_act && !wr;
    tb_en = wl || wh;
    tb_d = wd;
    oe_n = (wl || wh) ? 1'b1 : oe_req;
    if (wr) ref_mem[ea] = merge(ref_mem[ea], wd, wl, wh);
    @(posedge clk);
    #1;
    tb_en = 0;
    oe_n = oe_req;
    @(negedge clk);
    exp_v = (pend_v && !oe_n) ? pend_d : {DW{1'bz}};
    checks++;
    if (dq !== exp_v) begin
      errors++;
      $display("FAIL %s: dq=%h expected=%h", tag, dq, exp_v);
    end
    pend_v = rd;
    pend_d = ref_mem[ea];
  endtask

  task automatic wr_word(logic [AW-1:0] ad, logic [DW-1:0] d);
    idle(); cs_n = 0; a = ad; gw_n = 0; wd = d; tick(); idle();
  endtask

  task automatic rd_word(logic [AW-1:0] ad);
    idle(); cs_n = 0; a = ad; tick(); idle();
  endtask

  task automatic deselect();
    idle(); cs_n = 0; sc = 0; tick(); idle();
  endtask

  task automatic burst(logic [AW-1:0] ad, logic l);
    idle(); cs_n = 0; a = ad; lin = l; tick();
    idle(); adv_n = 0; tick(); tick(); tick();
    adv_n = 1; tick();
    idle(); tick();
  endtask

  initial begin
    idle(); a = '0; wd = '0; lin = 0; oe_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    tag = "R10 reset"; tick(); tick();
    tag = "R6 fill";
    for (int i = 0; i < DEPTH; i++) wr_word(AW'(i), pat(i));
    deselect();
    tag = "R3 single read"; rd_word(6'd3); deselect(); tick();
    tag = "R4 interleaved"; burst(6'd6, 0); deselect();
    tag = "R4 linear"; burst(6'd6, 1); deselect();
    tag = "R4 linear wrap"; burst(6'd15, 1); deselect();
    tag = "R5 lower lane";
    idle(); cs_n = 0; a = 6'd2; bw_n = 0; lo_n = 0; wd = 18'h2A5A5; tick(); idle();
    rd_word(6'd2); deselect(); tick();
    tag = "R5 upper lane";
    idle(); cs_n = 0; a = 6'd20; bw_n = 0; hi_n = 0; wd = 18'h1C3C3; tick(); idle();
    rd_word(6'd20); deselect(); tick();
    tag = "R5 unqualified";
    idle(); cs_n = 0; a = 6'd4; bw_n = 1; lo_n = 0; hi_n = 0; wd = 18'h0; tick(); idle();
    rd_word(6'd4); deselect(); tick();
    tag = "R6 global";
    idle(); cs_n = 0; a = 6'd21; gw_n = 0; bw_n = 0; wd = 18'h3F00F; tick(); idle();
    rd_word(6'd21); deselect(); tick();
    tag = "R7 host start";
    idle(); hs_n = 0; a = 6'd5; gw_n = 0; wd = 18'h15555; tick(); idle();
    tick(); deselect(); rd_word(6'd5); deselect(); tick();
    idle(); hs_n = 0; a = 6'd22; tick();
    idle(); gw_n = 0; wd = 18'h0BEEF; tick(); idle();
    tag = "R8 pass-through";
    rd_word(6'd22); deselect(); tick();
    wr_word(6'd9, 18'h3A0A0); rd_word(6'd9); deselect(); tick();
    idle(); cs_n = 0; a = 6'd9; bw_n = 0; hi_n = 0; wd = 18'h05F5F; tick(); idle();
    rd_word(6'd9); deselect(); tick();
    tag = "R2 gated host strobe";
    idle(); cs_n = 0; a = 6'd8; lin = 1; tick();
    idle(); hs_n = 0; sa_n = 1; a = 6'd40; adv_n = 0; tick();
    idle(); adv_n = 0; tick(); idle(); tick(); deselect(); tick();
    tag = "R1 deselect sel_c";
    idle(); cs_n = 0; a = 6'd10; sc = 0; tick();
    idle(); adv_n = 0; gw_n = 0; wd = 18'h0; tick(); tick(); idle(); tick();
    tag = "R1 deselect sel_b_n";
    idle(); cs_n = 0; a = 6'd11; sb_n = 1; tick();
    idle(); gw_n = 0; wd = 18'h0; tick(); idle(); tick();
    tag = "R1 readback";
    rd_word(6'd10); rd_word(6'd11); deselect(); tick();
    tag = "R9 output enable";
    rd_word(6'd12); oe_req = 1; tick(); oe_req = 0; tick(); deselect(); tick();
    tag = "R10 deselect timing";
    rd_word(6'd13); deselect(); tick(); tick();
    tag = "R11 write release";
    rd_word(6'd14); wr_word(6'd14, 18'h12345); tick(); deselect(); tick();
    tag = "R3 random";
    void'($urandom(32'd4242));
    for (int n = 0; n < 600; n++) begin
      int r = int'($urandom % 16);
      idle();
      a = AW'($urandom);
      wd = 18'($urandom);
      if (r < 3) cs_n = 0;
      else if (r < 5) hs_n = 0;
      adv_n = ($urandom % 3) == 0;
      if ((hs_n == 0 || cs_n == 0) && ($urandom % 2 == 0)) lin = ~lin;
      if ($urandom % 10 == 0) sc = 0;
      if ($urandom % 12 == 0) sa_n = 1;
      r = int'($urandom % 8);
      if (r == 0) gw_n = 0;
      else if (r == 1) begin bw_n = 0; lo_n = 0; end
      else if (r == 2) begin bw_n = 0; hi_n = 0; end
      oe_req = ($urandom % 9) == 0;
      tick();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R3: state=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule